// File: doc/BRIEF.md
# Double-Buffered 3x4 Pixel Color Matrix

The block converts a stream of three-component pixels from one color space to another. Every output channel is a weighted sum of the three input channels plus a constant: each channel row holds three gains and one offset, twelve coefficients in all. Pixels arrive with a valid strobe, are 12 bits per channel, and leave three cycles later with the result rounded and clamped to the 12-bit range.

Coefficients are loaded through a small word-wide write port into one of two programmable banks. A separate control word picks the live transform: pass-through, one of two built-in matrices for standard- and high-definition luma/chroma encoding, or either programmable bank. The pixel path never reads the banks directly; it reads a live copy that is refreshed only when the control word is written. Software therefore fills the idle bank at leisure and then flips the control word, and the switch lands between two pixels with no pixel seeing a half-loaded matrix.

Top module: `csc3x4_dbuf`

## Requirements
- R1: After reset the output valid is low and the live transform is the identity (pass-through), and both programmable banks hold all-zero coefficients.
- R2: With control code 0 each output pixel equals its input pixel exactly.
- R3: Every accepted input pixel produces exactly one output pixel, with output valid high exactly three clock cycles after the cycle in which input valid was high, in input order.
- R4: Gains are 16-bit two's complement with 13 fractional bits (0x2000 is unity). The offset is a 16-bit two's complement fraction of full scale with 13 fractional bits (0x1000 adds half of full scale, 2048 codes). Output = floor((g1*R + g2*G + g3*B + off*4096 + 4096) / 8192) before clamping, i.e. rounded half-up at the 13th fractional bit.
- R5: Results below zero give 0 and results above 4095 give 4095.
- R6: Address map: address k (0..5) writes bank A word k, address 8+k writes bank B word k; word k carries coefficient 2k in bits [15:0] and coefficient 2k+1 in bits [31:16]; coefficient index is row*4+column, column 3 being the offset. Pixel channel j (0 = R, 1 = G, 2 = B) sits at bits [12j+11:12j] on both pixel ports; output channel j uses coefficient row j.
- R7: A write to address 15 with bits [2:0] = 4 makes bank A live; with bits [2:0] = 5 makes bank B live.
- R8: Writes to a bank, including the live one, leave the output unchanged until the next write to address 15, which then loads the current bank contents.
- R9: Code 2 selects the fixed matrix rows {0x0E00,0xF447,0xFDB9,0x1000}, {0x082F,0x1012,0x031F,0x0200}, {0xFB47,0xF6B9,0x0E00,0x1000}; code 3 selects {0x0E00,0xF349,0xFEB7,0x1000}, {0x05D2,0x1394,0x01FA,0x0200}, {0xFCCB,0xF535,0x0E00,0x1000}.
- R10: A pixel accepted in the same cycle as a control write uses the previous transform; a pixel accepted in the next cycle uses the new one; pixels already in flight are not affected.
- R11: Control codes 1, 6 and 7 select pass-through.
- R12: Writes to addresses 6, 7 and 14 change no coefficient and no transform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| pix_in_vld | input | 1 | Input pixel valid |
| pix_in | input | 36 | Input pixel, three 12-bit channels |
| pix_out_vld | output | 1 | Output pixel valid |
| pix_out | output | 36 | Output pixel, three 12-bit clamped channels |

## Verification
On every cycle the assertions check the three-cycle valid delay, that the live transform holds still between control writes, that writes to unmapped addresses leave both banks untouched, and that a negative or oversized channel sum becomes 0 or 4095 one stage later. The arithmetic itself, the address and bit packing of the coefficients, the built-in matrix values and the exact cycle on which a bank swap takes effect relative to a streaming pixel are shown only by the bench's scenarios, which compare each output pixel with an independent model.

// File: rtl/csc_pkg.sv
package csc_pkg;

   localparam int COEF_W = 16;
   localparam int NCH    = 3;
   localparam int NTERM  = 4;
   localparam int NCOEF  = NCH * NTERM;
   localparam int NWORD  = NCOEF / 2;

   localparam logic [2:0] MD_PASS  = 3'd0;
   localparam logic [2:0] MD_F601  = 3'd2;
   localparam logic [2:0] MD_F709  = 3'd3;
   localparam logic [2:0] MD_BANKA = 3'd4;
   localparam logic [2:0] MD_BANKB = 3'd5;

   typedef logic [COEF_W-1:0] coef_t;
   typedef coef_t [NCOEF-1:0] coef_set_t;

   // unity gain on the diagonal, zero offsets
   function automatic coef_set_t ident_set(input int frac);
      coef_set_t s;
      s = '0;
      for (int r = 0; r < NCH; r++) s[r*NTERM + r] = coef_t'(1 << frac);
      return s;
   endfunction

   // standard-definition encoding matrix (S2.13 gains, S0.13 offsets)
   function automatic coef_set_t fix_sd();
      coef_set_t s;
      s[0] = 16'h0E00; s[1]  = 16'hF447; s[2]  = 16'hFDB9; s[3]  = 16'h1000;
      s[4] = 16'h082F; s[5]  = 16'h1012; s[6]  = 16'h031F; s[7]  = 16'h0200;
      s[8] = 16'hFB47; s[9]  = 16'hF6B9; s[10] = 16'h0E00; s[11] = 16'h1000;
      return s;
   endfunction

   // high-definition encoding matrix
   function automatic coef_set_t fix_hd();
      coef_set_t s;
      s[0] = 16'h0E00; s[1]  = 16'hF349; s[2]  = 16'hFEB7; s[3]  = 16'h1000;
      s[4] = 16'h05D2; s[5]  = 16'h1394; s[6]  = 16'h01FA; s[7]  = 16'h0200;
      s[8] = 16'hFCCB; s[9]  = 16'hF535; s[10] = 16'h0E00; s[11] = 16'h1000;
      return s;
   endfunction

endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
   import csc_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [2*COEF_W-1:0] wr_data,
   output coef_set_t           coefs
);
   localparam int SLOT_W = IDX_W + 1;

   if (2**IDX_W < NWORD) begin : g_bad_idx
      $error("csc_coef_bank: IDX_W too small for %0d words", NWORD);
   end

   logic [SLOT_W-1:0] lo_slot, hi_slot;
   assign lo_slot = {wr_idx, 1'b0};
   assign hi_slot = {wr_idx, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         coefs <= '0;
      end else if (wr_en) begin
         coefs[lo_slot] <= wr_data[COEF_W-1:0];
         coefs[hi_slot] <= wr_data[2*COEF_W-1:COEF_W];
      end
   end

endmodule

// File: rtl/csc_coef_ctl.sv
module csc_coef_ctl
   import csc_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int FRAC_W    = 13,
   parameter bit HAS_FIXED = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [2*COEF_W-1:0] wr_data,
   output coef_set_t           live_coef
);
   localparam int IDX_W   = 3;
   localparam int NBANK   = 2;
   localparam logic [ADDR_W-1:0] CTL_ADDR = {ADDR_W{1'b1}};
   localparam logic [IDX_W-1:0]  WORD_LIM = IDX_W'(NWORD);

   if (ADDR_W < IDX_W + 1) begin : g_bad_addr
      $error("csc_coef_ctl: ADDR_W must be at least %0d", IDX_W + 1);
   end
   if (HAS_FIXED && (FRAC_W != 13 || COEF_W != 16)) begin : g_bad_fix
      $error("csc_coef_ctl: built-in matrices need S2.13 coefficients");
   end

   logic              is_ctl;
   logic              word_ok;
   logic [ADDR_W-1:0] region;
   coef_set_t         bank_q [NBANK];
   coef_set_t         ident_w, sd_w, hd_w, nxt_live;
   logic [2:0]        mode_q;

   assign is_ctl  = wr_en && (wr_addr == CTL_ADDR);
   assign word_ok = wr_addr[IDX_W-1:0] < WORD_LIM;
   assign region  = wr_addr >> IDX_W;
   assign ident_w = ident_set(FRAC_W);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic bank_we;
      assign bank_we = wr_en && word_ok && (region == ADDR_W'(b));
      csc_coef_bank #(.IDX_W(IDX_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bank_we),
         .wr_idx  (wr_addr[IDX_W-1:0]),
         .wr_data (wr_data),
         .coefs   (bank_q[b])
      );
   end

   if (HAS_FIXED) begin : g_fixed
      assign sd_w = fix_sd();
      assign hd_w = fix_hd();
   end else begin : g_nofixed
      assign sd_w = ident_w;
      assign hd_w = ident_w;
   end

   always_comb begin
      unique case (wr_data[2:0])
         MD_BANKA: nxt_live = bank_q[0];
         MD_BANKB: nxt_live = bank_q[1];
         MD_F601:  nxt_live = sd_w;
         MD_F709:  nxt_live = hd_w;
         default:  nxt_live = ident_w;
      endcase
   end

   // live copy refreshed only by a control write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_coef <= ident_w;
         mode_q    <= MD_PASS;
      end else if (is_ctl) begin
         live_coef <= nxt_live;
         mode_q    <= wr_data[2:0];
      end
   end

   // R8
   live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_ctl |=> ($stable(live_coef) && $stable(mode_q)));

   // R12
   unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !is_ctl && !word_ok) |=> ($stable(bank_q[0]) && $stable(bank_q[1])));

endmodule

// File: rtl/csc_chan.sv
module csc_chan
   import csc_pkg::*;
#(
   parameter int PIX_W  = 12,
   parameter int FRAC_W = 13
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           stage_en,
   input  logic [NCH*PIX_W-1:0] pix_in,
   input  coef_t [NTERM-1:0]    row,
   output logic [PIX_W-1:0]     res
);
   localparam int PROD_W = COEF_W + PIX_W + 1;
   localparam int ACC_W  = PROD_W + 3;
   localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (FRAC_W - 1);
   localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << PIX_W) - 1);

   if (FRAC_W >= COEF_W) begin : g_bad_frac
      $error("csc_chan: FRAC_W must be below COEF_W");
   end

   logic signed [PROD_W-1:0] prod_d [NCH];
   logic signed [PROD_W-1:0] prod_q [NCH];
   logic signed [ACC_W-1:0]  off_d, off_q, sum_d, sum_q, shr;
   logic [PIX_W-1:0]         res_d;

   for (genvar j = 0; j < NCH; j++) begin : g_mul
      logic signed [PIX_W:0] px;
      assign px        = {1'b0, pix_in[j*PIX_W +: PIX_W]};
      assign prod_d[j] = px * $signed(row[j]);
   end

   // offset is a fraction of full scale: one offset LSB is 2^PIX_W accumulator LSBs
   assign off_d = ACC_W'($signed(row[NTERM-1])) <<< PIX_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < NCH; j++) prod_q[j] <= '0;
         off_q <= '0;
      end else if (stage_en[0]) begin
         for (int j = 0; j < NCH; j++) prod_q[j] <= prod_d[j];
         off_q <= off_d;
      end
   end

   always_comb begin
      sum_d = off_q + RND;
      for (int j = 0; j < NCH; j++) sum_d = sum_d + ACC_W'(prod_q[j]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           sum_q <= '0;
      else if (stage_en[1]) sum_q <= sum_d;
   end

   assign shr = sum_q >>> FRAC_W;

   always_comb begin
      if (sum_q[ACC_W-1])  res_d = '0;
      else if (shr > MAXV) res_d = {PIX_W{1'b1}};
      else                 res_d = shr[PIX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           res <= '0;
      else if (stage_en[2]) res <= res_d;
   end

   // R5
   neg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_en[2] && sum_q[ACC_W-1]) |=> (res == '0));

   // R5
   top_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_en[2] && !sum_q[ACC_W-1] && (shr > MAXV)) |=> (res == {PIX_W{1'b1}}));

endmodule

// File: rtl/csc3x4_dbuf.sv
module csc3x4_dbuf
   import csc_pkg::*;
#(
   parameter int PIX_W     = 12,
   parameter int FRAC_W    = 13,
   parameter int ADDR_W    = 4,
   parameter bit HAS_FIXED = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_wr_en,
   input  logic [ADDR_W-1:0]        cfg_addr,
   input  logic [2*COEF_W-1:0]      cfg_wdata,
   input  logic                     pix_in_vld,
   input  logic [NCH*PIX_W-1:0]     pix_in,
   output logic                     pix_out_vld,
   output logic [NCH*PIX_W-1:0]     pix_out
);
   localparam int STAGES = 3;

   if (PIX_W < 8) begin : g_bad_pix
      $error("csc3x4_dbuf: PIX_W must be at least 8");
   end

   coef_set_t          live_coef;
   logic [STAGES-1:0]  vld_q;
   logic [STAGES-1:0]  stage_en;
   logic [1:0]         warm_q;

   csc_coef_ctl #(
      .ADDR_W    (ADDR_W),
      .FRAC_W    (FRAC_W),
      .HAS_FIXED (HAS_FIXED)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr_en),
      .wr_addr   (cfg_addr),
      .wr_data   (cfg_wdata),
      .live_coef (live_coef)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= {vld_q[STAGES-2:0], pix_in_vld};
   end

   assign stage_en    = {vld_q[STAGES-2:0], pix_in_vld};
   assign pix_out_vld = vld_q[STAGES-1];

   for (genvar r = 0; r < NCH; r++) begin : g_ch
      csc_chan #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .stage_en (stage_en),
         .pix_in   (pix_in),
         .row      (live_coef[r*NTERM +: NTERM]),
         .res      (pix_out[r*PIX_W +: PIX_W])
      );
   end

   // cycles since reset, saturating, so the delay check never looks before reset
   always_ff @(posedge clk) begin
      if (!rst_n)             warm_q <= '0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
   end

   // R3
   vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd3) |-> (pix_out_vld == $past(pix_in_vld, 3)));

endmodule

// File: tb/sim_csc3x4_dbuf.sv
`timescale 1ns/1ps
module sim_csc3x4_dbuf;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        pix_in_vld = 1'b0;
   logic [35:0] pix_in = '0;
   logic        pix_out_vld;
   logic [35:0] pix_out;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [35:0] exp_q[$];
   int          when_q[$];
   string       tag_q[$];

   logic [15:0] m_live [12];
   logic [15:0] m_bank [2][12];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   csc3x4_dbuf u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .pix_in_vld(pix_in_vld), .pix_in(pix_in),
      .pix_out_vld(pix_out_vld), .pix_out(pix_out));

   function automatic logic [35:0] pk(input int r, input int g, input int b);
      return {12'(b), 12'(g), 12'(r)};
   endfunction

   function automatic logic [35:0] model(input logic [35:0] p);
      logic [35:0] o;
      for (int r = 0; r < 3; r++) begin
         longint acc = 4096;
         longint v;
         for (int j = 0; j < 3; j++)
            acc += longint'($signed(m_live[r*4+j])) * longint'(p[j*12 +: 12]);
         acc += longint'($signed(m_live[r*4+3])) * 4096;
         v = acc >>> 13;
         if (v < 0) v = 0;
         if (v > 4095) v = 4095;
         o[r*12 +: 12] = 12'(v);
      end
      return o;
   endfunction

   task automatic set_live(input logic [2:0] code);
      logic [15:0] s [12];
      for (int i = 0; i < 12; i++) s[i] = 16'h0;
      case (code)
         3'd4: for (int i = 0; i < 12; i++) s[i] = m_bank[0][i];
         3'd5: for (int i = 0; i < 12; i++) s[i] = m_bank[1][i];
         3'd2: begin
            s[0]=16'h0E00; s[1]=16'hF447; s[2]=16'hFDB9; s[3]=16'h1000;
            s[4]=16'h082F; s[5]=16'h1012; s[6]=16'h031F; s[7]=16'h0200;
            s[8]=16'hFB47; s[9]=16'hF6B9; s[10]=16'h0E00; s[11]=16'h1000;
         end
         3'd3: begin
            s[0]=16'h0E00; s[1]=16'hF349; s[2]=16'hFEB7; s[3]=16'h1000;
            s[4]=16'h05D2; s[5]=16'h1394; s[6]=16'h01FA; s[7]=16'h0200;
            s[8]=16'hFCCB; s[9]=16'hF535; s[10]=16'h0E00; s[11]=16'h1000;
         end
         default: begin s[0]=16'h2000; s[5]=16'h2000; s[10]=16'h2000; end
      endcase
      for (int i = 0; i < 12; i++) m_live[i] = s[i];
   endtask

   // one cycle of stimulus; expected result uses the transform live before this cycle's write
   task automatic step(input bit we, input logic [3:0] a, input logic [31:0] d,
                       input bit v, input logic [35:0] p, input string tag);
      @(negedge clk);
      cfg_wr_en = we; cfg_addr = a; cfg_wdata = d;
      pix_in_vld = v; pix_in = p;
      if (v) begin
         exp_q.push_back(model(p));
         when_q.push_back(cyc + 3);
         tag_q.push_back(tag);
      end
      if (we) begin
         if (a == 4'd15) set_live(d[2:0]);
         else if (a[2:0] < 3'd6) begin
            m_bank[a[3]][a[2:0]*2]   = d[15:0];
            m_bank[a[3]][a[2:0]*2+1] = d[31:16];
         end
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      step(1'b1, a, d, 1'b0, '0, "");
   endtask

   task automatic px(input logic [35:0] p, input string tag);
      step(1'b0, '0, '0, 1'b1, p, tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, '0, "");
   endtask

   // monitor: pops the scoreboard whenever the design presents a pixel
   always @(negedge clk) begin
      if (rst_n && pix_out_vld) begin
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R3: unexpected output %h, expected none", pix_out);
         end else begin
            logic [35:0] e;
            int w;
            string t;
            e = exp_q.pop_front(); w = when_q.pop_front(); t = tag_q.pop_front();
            if (pix_out !== e || cyc != w) begin
               failures++;
               $display("FAIL %s R3: got %h at cycle %0d, expected %h at cycle %0d",
                        t, pix_out, cyc, e, w);
            end
         end
      end
   end

   initial begin
      #(5.0 * 50000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < 2; b++) for (int i = 0; i < 12; i++) m_bank[b][i] = 16'h0;
      set_live(3'd0);
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      checks++;
      if (pix_out_vld !== 1'b0) begin
         failures++;
         $display("FAIL R1: out valid %b, expected 0", pix_out_vld);
      end

      // R1 R2: default after reset is pass-through
      px(pk(0, 0, 0), "R1");
      px(pk(4095, 1, 2048), "R1 R2");
      px(pk(123, 3000, 77), "R2");
      idle(2);
      px(pk(4095, 4095, 4095), "R2");
      idle(4);

      // R1: bank B starts at zero, selecting it gives black
      wr(4'd15, 32'd5);
      px(pk(1000, 2000, 3000), "R1 R7");
      idle(4);

      // R4 R6 R7: limited-range matrix in bank A
      wr(4'd0, 32'h0000_1B60); wr(4'd1, 32'h0200_0000);
      wr(4'd2, 32'h1B60_0000); wr(4'd3, 32'h0200_0000);
      wr(4'd4, 32'h0000_0000); wr(4'd5, 32'h0200_1B60);
      wr(4'd15, 32'd4);
      px(pk(4095, 0, 2048), "R4 R6 R7");
      px(pk(0, 4095, 1), "R4 R6");
      px(pk(100, 200, 300), "R4 R6 R7");
      idle(4);

      // R5 R4: bank B with saturating, negative and half-LSB gains
      wr(4'd8,  32'h0000_7FFF); wr(4'd9,  32'h0000_0000);
      wr(4'd10, 32'h2000_C000); wr(4'd11, 32'h0000_0000);
      wr(4'd12, 32'h0000_1000); wr(4'd13, 32'h0000_0000);
      wr(4'd15, 32'd5);
      px(pk(3, 0, 0), "R4 R7");
      px(pk(1, 4095, 0), "R4 R5");
      px(pk(2000, 0, 0), "R5");
      px(pk(4095, 100, 7), "R5");
      idle(4);

      // R8: rewrite the live bank, output must not change until the control write
      wr(4'd8, 32'h0000_2000);
      wr(4'd12, 32'h0000_2000);
      px(pk(2000, 10, 20), "R8");
      idle(3);
      wr(4'd15, 32'd5);
      px(pk(2000, 10, 20), "R8");
      idle(4);

      // R10: swap while pixels stream back to back
      px(pk(500, 600, 700), "R10");
      step(1'b1, 4'd15, 32'd4, 1'b1, pk(500, 600, 700), "R10");
      px(pk(500, 600, 700), "R10");
      step(1'b1, 4'd15, 32'd0, 1'b1, pk(800, 900, 1000), "R10");
      px(pk(800, 900, 1000), "R10");
      idle(4);

      // R9: fixed matrices
      wr(4'd15, 32'd2);
      px(pk(4095, 4095, 4095), "R9");
      px(pk(4095, 0, 0), "R9");
      px(pk(100, 2000, 3900), "R9");
      wr(4'd15, 32'd3);
      px(pk(4095, 4095, 4095), "R9");
      px(pk(0, 0, 4095), "R9");
      px(pk(1234, 2345, 3456), "R9");
      idle(4);

      // R11: undefined codes are pass-through
      wr(4'd15, 32'd1);
      px(pk(11, 22, 33), "R11");
      wr(4'd15, 32'd6);
      px(pk(44, 55, 66), "R11");
      wr(4'd15, 32'd7);
      px(pk(4000, 5, 4095), "R11");
      idle(4);

      // R12: unmapped addresses change nothing
      wr(4'd15, 32'd4);
      wr(4'd6, 32'hFFFF_FFFF); wr(4'd7, 32'h1234_5678); wr(4'd14, 32'hDEAD_BEEF);
      px(pk(100, 200, 300), "R12");
      wr(4'd15, 32'd4);
      px(pk(100, 200, 300), "R12");
      wr(4'd15, 32'd5);
      px(pk(2000, 10, 20), "R12");
      idle(6);

      checks++;
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL R3: %0d outputs missing, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule